// File: doc/BRIEF.md
# Speculative and Committed Register File Pair

This block keeps two copies of the register state so that exceptions stay precise in an out-of-order core. The speculative copy is the one that operand reads use. It is updated when an instruction finishes executing. The committed copy changes only when instructions retire in program order.

Each speculative entry has a ready flag and one payload field. The payload holds the result value when the entry is ready. While a producer is still in flight, the payload holds that producer's tag instead. Three events change the speculative copy:

- **Rename at decode.** The destination entry is marked pending and takes the new tag.
- **Completion.** A result is accepted only from the producer whose tag is still recorded, which is the youngest writer of that register.
- **Exception at retirement.** The whole committed copy is loaded into the speculative copy in one cycle, which throws away every pending tag.

The retirement queue and the execution units sit outside the block. They drive the decode, completion and retirement inputs.

Top module: `precise_regfile`

## Requirements
- R1: After reset, every register reads ready with value 0 on every read port, and the committed copy also holds 0 everywhere.
- R2: A decode to register d with tag t makes register d read not ready from the next cycle. Its value reads as t, zero-extended in the low bits.
- R3: A completion to register d with tag t, while d is pending with tag t, makes d read ready with the completion data from the next cycle.
- R4: A completion is ignored when its register is already ready or holds a different (younger) tag. The register reads exactly as before.
- R5: When a decode and a completion target the same register in one cycle, the decode wins. The register reads pending with the decode tag.
- R6: A decode and a completion to different registers in the same cycle both take effect.
- R7: A retirement without exception writes its data into the committed copy only. Speculative reads are unchanged by it.
- R8: A retirement with the exception flag raised loads every speculative entry from the committed copy, ready, by the next cycle. The excepting instruction's own retirement data is not written anywhere.
- R9: A decode or completion presented in the same cycle as an exception retirement is discarded.
- R10: Reads are combinational from the speculative state after the last clock edge. Each read port selects its own register independently (port k uses register-select bits [k*RW +: RW]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Decode renames a destination this cycle |
| dec_reg | input | RW | Destination register of the decode |
| dec_tag | input | TW | Producer tag assigned at decode |
| cmp_en | input | 1 | A result completes this cycle |
| cmp_reg | input | RW | Destination register of the completing result |
| cmp_tag | input | TW | Tag of the completing producer |
| cmp_data | input | DW | Completed result value |
| cmt_en | input | 1 | Oldest instruction retires this cycle |
| cmt_exc | input | 1 | Retiring instruction raises an exception |
| cmt_reg | input | RW | Destination register of the retiring instruction |
| cmt_data | input | DW | Value written to the committed copy |
| rd_reg | input | NRD*RW | Register selects, one field per read port |
| rd_ready | output | NRD | Ready flag per read port |
| rd_value | output | NRD*DW | Data when ready, tag otherwise, per read port |

## Verification
The bench renames one register twice and then completes the older tag. A design that checked only the register and not the tag would overwrite the newer rename with a stale value. It repeats a completion on an already ready entry, which a design that ignores the ready flag could match by accident. It collides a decode and a completion on one register to catch reversed priority. It raises an exception together with a decode, a completion and retirement data, then reads back registers that were pending, written or untouched. A partial copy, a leftover tag, or an excepting result that leaked into the committed copy each shows up as a wrong value or a wrong ready flag.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
  // Youngest-writer test: entry must be pending and still hold this tag.
  function automatic logic youngest_writer(input logic ready,
                                           input logic [63:0] held,
                                           input logic [63:0] tag);
    return !ready && (held == tag);
  endfunction

  // Register index to flat bit offset.
  function automatic int unsigned slot_base(input int unsigned idx,
                                            input int unsigned width);
    return idx * width;
  endfunction
endpackage

// File: rtl/ffa_arch_file.sv
module ffa_arch_file #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int RW   = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_reg,
  input  logic [DW-1:0]        wr_data,
  output logic [NREG*DW-1:0]   state_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_en && (wr_reg == RW'(i)))        q <= wr_data;
    end
    assign state_flat[i*DW +: DW] = q;
  end
endmodule

// File: rtl/ffa_future_file.sv
module ffa_future_file
  import ffa_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 4,
  parameter int RW   = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_en,
  input  logic [RW-1:0]        dec_reg,
  input  logic [TW-1:0]        dec_tag,
  input  logic                 cmp_en,
  input  logic [RW-1:0]        cmp_reg,
  input  logic [TW-1:0]        cmp_tag,
  input  logic [DW-1:0]        cmp_data,
  input  logic                 restore,
  input  logic [NREG*DW-1:0]   arch_flat,
  output logic [NREG-1:0]      ready_vec,
  output logic [NREG*DW-1:0]   val_flat,
  output logic                 cmp_hit
);
  logic [DW-1:0] cmp_held;
  assign cmp_held = val_flat[slot_base(32'(cmp_reg), DW) +: DW];
  assign cmp_hit  = cmp_en && youngest_writer(ready_vec[cmp_reg], 64'(cmp_held), 64'(cmp_tag));

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic          rdy;
    logic [DW-1:0] val;
    logic          dec_here, cmp_here;
    assign dec_here = dec_en && (dec_reg == RW'(i));
    assign cmp_here = cmp_hit && (cmp_reg == RW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy <= 1'b1;
        val <= '0;
      end else if (restore) begin
        rdy <= 1'b1;
        val <= arch_flat[i*DW +: DW];
      end else if (dec_here) begin
        rdy <= 1'b0;
        val <= DW'(dec_tag);
      end else if (cmp_here) begin
        rdy <= 1'b1;
        val <= cmp_data;
      end
    end
    assign ready_vec[i]        = rdy;
    assign val_flat[i*DW +: DW] = val;
  end
endmodule

// File: rtl/ffa_read_port.sv
module ffa_read_port
  import ffa_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int RW   = $clog2(NREG)
) (
  input  logic [RW-1:0]        sel,
  input  logic [NREG-1:0]      ready_vec,
  input  logic [NREG*DW-1:0]   val_flat,
  output logic                 ready,
  output logic [DW-1:0]        value
);
  assign ready = ready_vec[sel];
  assign value = val_flat[slot_base(32'(sel), DW) +: DW];
endmodule

// File: rtl/precise_regfile.sv
module precise_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 4,
  parameter int NRD  = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_en,
  input  logic [RW-1:0]        dec_reg,
  input  logic [TW-1:0]        dec_tag,
  input  logic                 cmp_en,
  input  logic [RW-1:0]        cmp_reg,
  input  logic [TW-1:0]        cmp_tag,
  input  logic [DW-1:0]        cmp_data,
  input  logic                 cmt_en,
  input  logic                 cmt_exc,
  input  logic [RW-1:0]        cmt_reg,
  input  logic [DW-1:0]        cmt_data,
  input  logic [NRD*RW-1:0]    rd_reg,
  output logic [NRD-1:0]       rd_ready,
  output logic [NRD*DW-1:0]    rd_value
);
  // Named internal events for the checker.
  logic                copy_evt;
  logic                arch_wr;
  logic                cmp_hit;
  logic [NREG-1:0]     fut_ready;
  logic [NREG*DW-1:0]  fut_val_flat;
  logic [NREG*DW-1:0]  arch_flat;

  assign copy_evt = cmt_en && cmt_exc;
  assign arch_wr  = cmt_en && !cmt_exc;

  ffa_arch_file #(.NREG(NREG), .DW(DW), .RW(RW)) u_arch (
    .clk(clk), .rst_n(rst_n),
    .wr_en(arch_wr), .wr_reg(cmt_reg), .wr_data(cmt_data),
    .state_flat(arch_flat)
  );

  ffa_future_file #(.NREG(NREG), .DW(DW), .TW(TW), .RW(RW)) u_fut (
    .clk(clk), .rst_n(rst_n),
    .dec_en(dec_en), .dec_reg(dec_reg), .dec_tag(dec_tag),
    .cmp_en(cmp_en), .cmp_reg(cmp_reg), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .restore(copy_evt), .arch_flat(arch_flat),
    .ready_vec(fut_ready), .val_flat(fut_val_flat), .cmp_hit(cmp_hit)
  );

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    ffa_read_port #(.NREG(NREG), .DW(DW), .RW(RW)) u_rp (
      .sel(rd_reg[k*RW +: RW]),
      .ready_vec(fut_ready), .val_flat(fut_val_flat),
      .ready(rd_ready[k]), .value(rd_value[k*DW +: DW])
    );
  end
endmodule

// File: rtl/ffa_checker.sv
module ffa_checker #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 4,
  parameter int RW   = $clog2(NREG)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dec_en,
  input logic [RW-1:0]       dec_reg,
  input logic                cmp_en,
  input logic [RW-1:0]       cmp_reg,
  input logic [DW-1:0]       cmp_data,
  input logic                cmp_hit,
  input logic                copy_evt,
  input logic                arch_wr,
  input logic [NREG-1:0]     fut_ready,
  input logic [NREG*DW-1:0]  fut_val_flat,
  input logic [NREG*DW-1:0]  arch_flat
);
  AST_DEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !copy_evt) |=> !fut_ready[$past(dec_reg)]); // R2

  AST_CMP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !copy_evt && !(dec_en && dec_reg == cmp_reg)) |=>
      (fut_ready[$past(cmp_reg)] && fut_val_flat[$past(cmp_reg)*DW +: DW] == $past(cmp_data))); // R3

  AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !cmp_hit && !copy_evt && !(dec_en && dec_reg == cmp_reg)) |=>
      (fut_ready[$past(cmp_reg)] == $past(fut_ready[cmp_reg]) &&
       fut_val_flat[$past(cmp_reg)*DW +: DW] == $past(fut_val_flat[cmp_reg*DW +: DW]))); // R4

  AST_DEC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && cmp_en && dec_reg == cmp_reg && !copy_evt) |=> !fut_ready[$past(dec_reg)]); // R5

  AST_ARCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !arch_wr |=> $stable(arch_flat)); // R7

  AST_RESTORE_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |=> (&fut_ready)); // R8

  AST_RESTORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |=> (fut_val_flat == $past(arch_flat))); // R9
endmodule

bind precise_regfile ffa_checker #(.NREG(NREG), .DW(DW), .TW(TW), .RW(RW)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .dec_en(dec_en), .dec_reg(dec_reg),
  .cmp_en(cmp_en), .cmp_reg(cmp_reg), .cmp_data(cmp_data), .cmp_hit(cmp_hit),
  .copy_evt(copy_evt), .arch_wr(arch_wr),
  .fut_ready(fut_ready), .fut_val_flat(fut_val_flat), .arch_flat(arch_flat)
);

// File: tb/test_precise_regfile.sv
`timescale 1ns/1ps
module test_precise_regfile;
  localparam int NREG = 8, DW = 16, TW = 4, NRD = 2, RW = 3;

  logic clk = 0, rst_n = 0;
  logic dec_en = 0, cmp_en = 0, cmt_en = 0, cmt_exc = 0;
  logic [RW-1:0] dec_reg = 0, cmp_reg = 0, cmt_reg = 0;
  logic [TW-1:0] dec_tag = 0, cmp_tag = 0;
  logic [DW-1:0] cmp_data = 0, cmt_data = 0;
  logic [NRD*RW-1:0] rd_reg = 0;
  logic [NRD-1:0] rd_ready;
  logic [NRD*DW-1:0] rd_value;

  always #4 clk = ~clk;

  precise_regfile #(.NREG(NREG), .DW(DW), .TW(TW), .NRD(NRD)) i_precise_regfile (
    .clk(clk), .rst_n(rst_n),
    .dec_en(dec_en), .dec_reg(dec_reg), .dec_tag(dec_tag),
    .cmp_en(cmp_en), .cmp_reg(cmp_reg), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .cmt_en(cmt_en), .cmt_exc(cmt_exc), .cmt_reg(cmt_reg), .cmt_data(cmt_data),
    .rd_reg(rd_reg), .rd_ready(rd_ready), .rd_value(rd_value)
  );

  typedef struct packed {
    logic de; logic [2:0] dr; logic [3:0] dt;
    logic ce; logic [2:0] cr; logic [3:0] ct; logic [15:0] cd;
    logic me; logic mx; logic [2:0] mr; logic [15:0] md;
    logic [2:0] chk; logic er; logic [15:0] ev; logic [3:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [0:NV-1] = '{
    '{1,1,3, 0,0,0,16'h0,    0,0,0,16'h0,    1,0,16'h0003, 2},  // R2 rename r1
    '{0,0,0, 1,1,3,16'h1234, 0,0,0,16'h0,    1,1,16'h1234, 3},  // R3 fill r1
    '{1,2,5, 0,0,0,16'h0,    0,0,0,16'h0,    2,0,16'h0005, 2},  // R2 rename r2
    '{1,2,6, 0,0,0,16'h0,    0,0,0,16'h0,    2,0,16'h0006, 2},  // R2 younger rename
    '{0,0,0, 1,2,5,16'hAAAA, 0,0,0,16'h0,    2,0,16'h0006, 4},  // R4 stale tag
    '{0,0,0, 1,2,6,16'hBBBB, 0,0,0,16'h0,    2,1,16'hBBBB, 3},  // R3 youngest fills
    '{0,0,0, 1,2,6,16'hCCCC, 0,0,0,16'h0,    2,1,16'hBBBB, 4},  // R4 already ready
    '{1,3,2, 0,0,0,16'h0,    0,0,0,16'h0,    3,0,16'h0002, 2},  // R2
    '{1,3,9, 1,3,2,16'h2222, 0,0,0,16'h0,    3,0,16'h0009, 5},  // R5 decode wins
    '{1,4,1, 1,3,9,16'h3333, 0,0,0,16'h0,    3,1,16'h3333, 6},  // R6 completion side
    '{0,0,0, 0,0,0,16'h0,    0,0,0,16'h0,    4,0,16'h0001, 6},  // R6 decode side
    '{0,0,0, 0,0,0,16'h0,    1,0,1,16'h1234, 1,1,16'h1234, 7},  // R7
    '{0,0,0, 0,0,0,16'h0,    1,0,5,16'h5555, 5,1,16'h0000, 7},  // R7 spec copy untouched
    '{0,0,0, 0,0,0,16'h0,    1,0,2,16'hBBBB, 2,1,16'hBBBB, 7},  // R7
    '{1,7,4, 1,4,1,16'h4444, 1,1,6,16'h6666, 5,1,16'h5555, 8},  // R8 restore
    '{0,0,0, 0,0,0,16'h0,    0,0,0,16'h0,    6,1,16'h0000, 8},  // R8 excepting data dropped
    '{0,0,0, 0,0,0,16'h0,    0,0,0,16'h0,    7,1,16'h0000, 9},  // R9 decode discarded
    '{0,0,0, 0,0,0,16'h0,    0,0,0,16'h0,    4,1,16'h0000, 9},  // R9 completion discarded
    '{0,0,0, 0,0,0,16'h0,    0,0,0,16'h0,    3,1,16'h0000, 8},  // R8 speculative value gone
    '{0,0,0, 0,0,0,16'h0,    0,0,0,16'h0,    2,1,16'hBBBB, 8},  // R8
    '{0,0,0, 0,0,0,16'h0,    0,0,0,16'h0,    1,1,16'h1234, 8}   // R8
  };

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string req, input logic gr, input logic er,
                       input logic [DW-1:0] gv, input logic [DW-1:0] ev);
    checks++;
    if (gr !== er || gv !== ev) begin
      errors++;
      $display("FAIL %s: ready=%0b value=%h, expected ready=%0b value=%h", req, gr, gv, er, ev);
    end
  endtask

  task automatic clear_ops();
    dec_en = 0; cmp_en = 0; cmt_en = 0; cmt_exc = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int r = 0; r < NREG; r++) begin  // R1 reset state, both ports
      rd_reg = {RW'(NREG-1-r), RW'(r)};
      #1;
      check("R1", rd_ready[0], 1'b1, rd_value[DW-1:0], '0);
      check("R1", rd_ready[1], 1'b1, rd_value[2*DW-1:DW], '0);
    end
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dec_en = TBL[i].de; dec_reg = TBL[i].dr; dec_tag = TBL[i].dt;
      cmp_en = TBL[i].ce; cmp_reg = TBL[i].cr; cmp_tag = TBL[i].ct; cmp_data = TBL[i].cd;
      cmt_en = TBL[i].me; cmt_exc = TBL[i].mx; cmt_reg = TBL[i].mr; cmt_data = TBL[i].md;
      @(negedge clk);
      clear_ops();
      rd_reg[RW-1:0] = TBL[i].chk;
      #1;
      check($sformatf("R%0d vec%0d", TBL[i].rq, i), rd_ready[0], TBL[i].er,
            rd_value[DW-1:0], TBL[i].ev);
    end

    // R10: independent ports, combinational read of current state
    @(negedge clk);
    rd_reg = {3'd2, 3'd1};
    #1;
    check("R10 port0", rd_ready[0], 1'b1, rd_value[DW-1:0], 16'h1234);
    check("R10 port1", rd_ready[1], 1'b1, rd_value[2*DW-1:DW], 16'hBBBB);
    dec_en = 1; dec_reg = 3'd2; dec_tag = 4'hE;
    @(negedge clk); clear_ops();
    #1;
    check("R10 port1 pending", rd_ready[1], 1'b0, rd_value[2*DW-1:DW], 16'h000E);
    check("R10 port0 unaffected", rd_ready[0], 1'b1, rd_value[DW-1:0], 16'h1234);

    // R1: reset in mid-run returns everything to ready zero
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 rerun port0", rd_ready[0], 1'b1, rd_value[DW-1:0], '0);
    check("R1 rerun port1", rd_ready[1], 1'b1, rd_value[2*DW-1:DW], '0);
    // R1: committed copy cleared too, seen through an exception restore
    @(negedge clk); cmt_en = 1; cmt_exc = 1;
    @(negedge clk); clear_ops(); #1;
    check("R1 committed zero", rd_ready[0], 1'b1, rd_value[DW-1:0], '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule